// File: doc/BRIEF.md
# Prescaled Timer Counter with Reload Alignment

This block is a timer counter that advances once per prescaled tick of its input clock. A 3-bit selector picks the division ratio from a fixed, non-uniform set of ratios. A 2-bit width selector limits the counter and its top value to 8, 16 or 32 bits. The counter counts up or down between zero and a top value. Each time it wraps, it emits a one-cycle pulse.

A retrigger strobe reloads the counter to its start value. That is zero when counting up and the top value when counting down. A 2-bit alignment mode decides when the reload lands:
- on the next input clock edge;
- on the next prescaled tick;
- on the next input clock edge while also restarting the prescaler, so that the first period after the reload is a full one.

An auto-lock option raises a sticky lock-update flag on every wrap or applied reload. A separate clear strobe drops the flag.

Top module: `presc_timer`

## Requirements
- R1: Prescaler codes 0 to 7 give division ratios 1, 2, 4, 8, 16, 64, 256 and 1024. The prescaler restarts from zero when enabled. Starting from that point, the counter advances on the edge that ends every N-th enabled cycle, where N is the ratio, and is stable on all other edges.
- R2: When counting up (direction input 0), the counter wraps from the top value to 0 on a tick. In the cycle where the counter shows 0, the wrap output is high for exactly one cycle.
- R3: When counting down (direction input 1), the counter wraps from 0 to the top value on a tick. In the cycle where the counter shows the top value, the wrap output is high for one cycle.
- R4: Width code 1 selects 8 bits, code 0 selects 16 bits, code 2 selects 32 bits, and the reserved code 3 behaves as 16 bits. The counter value and the top value are both truncated to the selected width.
- R5: With alignment code 0, a retrigger sampled on an edge reloads the counter on that same edge. The prescaler phase is not affected.
- R6: With alignment code 1, a retrigger is held pending until the next prescaled tick. On that tick the counter reloads instead of counting.
- R7: With alignment code 2, a retrigger reloads on the sampling edge and restarts the prescaler from zero. The next count then comes a full N cycles later.
- R8: The reserved alignment code 3 behaves as code 0.
- R9: While auto-lock is enabled, every wrap or applied reload sets the lock-update flag on that edge. The clear strobe drops the flag. Set wins over clear on the same edge.
- R10: While auto-lock is disabled, wraps and reloads leave the lock-update flag unchanged.
- R11: While the enable input is low, the counter holds, no wrap is signalled, retriggers are ignored and the prescaler is held at zero.
- R12: Asynchronous reset clears the counter, the wrap output and the lock-update flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counting enable |
| dir_down_i | input | 1 | 0 = count up, 1 = count down |
| retrig_i | input | 1 | Retrigger (reload) strobe |
| top_i | input | 32 | Top (period) value |
| presc_sel_i | input | 3 | Prescaler ratio code |
| sync_mode_i | input | 2 | Reload alignment code |
| width_mode_i | input | 2 | Counter width code |
| auto_lock_i | input | 1 | Auto-lock enable |
| lock_clr_i | input | 1 | Clear strobe for the lock-update flag |
| cnt_o | output | 32 | Counter value, masked to the selected width |
| wrap_o | output | 1 | One-cycle overflow/underflow pulse |
| lock_upd_o | output | 1 | Lock-update flag |

## Verification
The properties assume that the direction, width, top and alignment inputs change only at clock edges. They also assume that the width code does not change while a wrap is being checked, because the expected top value is masked with the current width code. The stimulus changes these configuration inputs only between scenarios, and each scenario starts from a reset. Strobes are driven for whole cycles, half a period away from the sampling edge.

// File: rtl/presc_timer_pkg.sv
package presc_timer_pkg;
  localparam int PRESC_W = 10;

  localparam logic [1:0] WID_16 = 2'd0;
  localparam logic [1:0] WID_8  = 2'd1;
  localparam logic [1:0] WID_32 = 2'd2;

  localparam logic [1:0] ALN_CLK   = 2'd0;
  localparam logic [1:0] ALN_TICK  = 2'd1;
  localparam logic [1:0] ALN_RESTART = 2'd2;

  // low bits that must all be one for a tick
  function automatic logic [PRESC_W-1:0] ratio_mask(input logic [2:0] sel);
    case (sel)
      3'd0: ratio_mask = 10'd0;
      3'd1: ratio_mask = 10'd1;
      3'd2: ratio_mask = 10'd3;
      3'd3: ratio_mask = 10'd7;
      3'd4: ratio_mask = 10'd15;
      3'd5: ratio_mask = 10'd63;
      3'd6: ratio_mask = 10'd255;
      default: ratio_mask = 10'd1023;
    endcase
  endfunction

  function automatic logic [31:0] width_mask(input logic [1:0] w);
    case (w)
      WID_8:   width_mask = 32'h0000_00FF;
      WID_32:  width_mask = 32'hFFFF_FFFF;
      default: width_mask = 32'h0000_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/presc_timer_div.sv
module presc_timer_div
  import presc_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PRESC_W-1:0] div_q;
  logic [PRESC_W-1:0] msk;

  assign msk    = ratio_mask(sel_i);
  assign tick_o = en_i && ((div_q & msk) == msk);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (!en_i || clr_i)  div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/presc_timer_core.sv
module presc_timer_core
  import presc_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dir_down_i,
  input  logic             retrig_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [1:0]       sync_mode_i,
  input  logic [1:0]       width_mode_i,
  output logic [CNT_W-1:0] cnt_raw_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             reload_evt_o,
  output logic             wrap_evt_o,
  output logic             presc_clr_o
);
  logic [CNT_W-1:0] cnt_q, wmsk, top_m, cnt_m, start_v, cnt_d;
  logic             pend_q, tick_aligned, step;

  assign wmsk    = width_mask(width_mode_i);
  assign top_m   = top_i & wmsk;
  assign cnt_m   = cnt_q & wmsk;
  assign start_v = dir_down_i ? top_m : '0;
  assign tick_aligned = (sync_mode_i == ALN_TICK);

  assign reload_evt_o = en_i && (tick_aligned ? (tick_i && (pend_q || retrig_i)) : retrig_i);
  assign presc_clr_o  = reload_evt_o && (sync_mode_i == ALN_RESTART);
  assign step         = en_i && tick_i && !reload_evt_o;
  assign wrap_evt_o   = step && (dir_down_i ? (cnt_m == '0) : (cnt_m == top_m));

  always_comb begin
    if (reload_evt_o || wrap_evt_o) cnt_d = start_v;
    else if (step)                  cnt_d = (dir_down_i ? cnt_m - 1'b1 : cnt_m + 1'b1) & wmsk;
    else                            cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_o <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_o <= wrap_evt_o;
      if (!en_i || !tick_aligned || reload_evt_o) pend_q <= 1'b0;
      else if (retrig_i)                          pend_q <= 1'b1;
    end
  end

  assign cnt_raw_o = cnt_q;
  assign cnt_o     = cnt_m;
endmodule

// File: rtl/presc_timer_lock.sv
module presc_timer_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_lock_i,
  input  logic evt_i,
  input  logic clr_i,
  output logic lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   lock_o <= 1'b0;
    else if (auto_lock_i && evt_i) lock_o <= 1'b1;
    else if (clr_i)                lock_o <= 1'b0;
  end
endmodule

// File: rtl/presc_timer.sv
module presc_timer
  import presc_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dir_down_i,
  input  logic             retrig_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [2:0]       presc_sel_i,
  input  logic [1:0]       sync_mode_i,
  input  logic [1:0]       width_mode_i,
  input  logic             auto_lock_i,
  input  logic             lock_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             lock_upd_o
);
  logic             tick, presc_clr, reload_evt, wrap_evt;
  logic [CNT_W-1:0] cnt_raw;

  presc_timer_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .clr_i  (presc_clr),
    .sel_i  (presc_sel_i),
    .tick_o (tick)
  );

  presc_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .dir_down_i   (dir_down_i),
    .retrig_i     (retrig_i),
    .tick_i       (tick),
    .top_i        (top_i),
    .sync_mode_i  (sync_mode_i),
    .width_mode_i (width_mode_i),
    .cnt_raw_o    (cnt_raw),
    .cnt_o        (cnt_o),
    .wrap_o       (wrap_o),
    .reload_evt_o (reload_evt),
    .wrap_evt_o   (wrap_evt),
    .presc_clr_o  (presc_clr)
  );

  presc_timer_lock u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .auto_lock_i (auto_lock_i),
    .evt_i       (wrap_evt || reload_evt),
    .clr_i       (lock_clr_i),
    .lock_o      (lock_upd_o)
  );
endmodule

// File: rtl/presc_timer_chk.sv
module presc_timer_chk
  import presc_timer_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        dir_down_i,
  input logic        retrig_i,
  input logic [31:0] top_i,
  input logic [1:0]  sync_mode_i,
  input logic [1:0]  width_mode_i,
  input logic        auto_lock_i,
  input logic        lock_clr_i,
  input logic [31:0] cnt_o,
  input logic        wrap_o,
  input logic        lock_upd_o,
  input logic        tick,
  input logic        reload_evt,
  input logic        wrap_evt,
  input logic [31:0] cnt_raw
);
  assert_hold_no_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !tick && !reload_evt |=> $stable(cnt_raw));

  assert_wrap_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o && !$past(dir_down_i) |-> cnt_o == 32'd0);

  assert_wrap_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o && $past(dir_down_i) |-> cnt_o == ($past(top_i) & width_mask(width_mode_i)));

  assert_sync_clk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && retrig_i && sync_mode_i == ALN_CLK && !dir_down_i |=> cnt_raw == 32'd0);

  assert_defer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && retrig_i && sync_mode_i == ALN_TICK && !tick |=> $stable(cnt_raw));

  assert_lock_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_lock_i && (wrap_evt || reload_evt) |=> lock_upd_o);

  assert_lock_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_lock_i && !lock_clr_i |=> $stable(lock_upd_o));

  assert_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_raw) && !wrap_o);
endmodule

bind presc_timer presc_timer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .dir_down_i   (dir_down_i),
  .retrig_i     (retrig_i),
  .top_i        (top_i),
  .sync_mode_i  (sync_mode_i),
  .width_mode_i (width_mode_i),
  .auto_lock_i  (auto_lock_i),
  .lock_clr_i   (lock_clr_i),
  .cnt_o        (cnt_o),
  .wrap_o       (wrap_o),
  .lock_upd_o   (lock_upd_o),
  .tick         (tick),
  .reload_evt   (reload_evt),
  .wrap_evt     (wrap_evt),
  .cnt_raw      (cnt_raw)
);

// File: tb/presc_timer_test.sv
module presc_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, dir = 1'b0, retrig = 1'b0, alock = 1'b0, lclr = 1'b0;
  logic [31:0] top = '0;
  logic [2:0]  psel = '0;
  logic [1:0]  smode = '0, wmode = '0;
  logic [31:0] cnt;
  logic        wrap, lock;
  int          checks = 0, fails = 0;

  always #10 clk = ~clk;

  presc_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .dir_down_i(dir), .retrig_i(retrig),
    .top_i(top), .presc_sel_i(psel), .sync_mode_i(smode), .width_mode_i(wmode),
    .auto_lock_i(alock), .lock_clr_i(lclr), .cnt_o(cnt), .wrap_o(wrap), .lock_upd_o(lock)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; en = 0; dir = 0; retrig = 0; alock = 0; lclr = 0;
    top = '0; psel = '0; smode = '0; wmode = '0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic t_reset;
    do_reset;
    chk("R12 cnt", cnt, 0);
    chk("R12 wrap", {31'd0, wrap}, 0);
    chk("R12 lock", {31'd0, lock}, 0);
  endtask

  task automatic t_presc;
    int ratio [8] = '{1, 2, 4, 8, 16, 64, 256, 1024};
    for (int c = 0; c < 8; c++) begin
      do_reset;
      psel = 3'(c); top = 32'hFFFF; en = 1;
      step(3 * ratio[c] - 1);
      chk($sformatf("R1 code%0d before", c), cnt, 2);
      step(1);
      chk($sformatf("R1 code%0d at", c), cnt, 3);
    end
  endtask

  task automatic t_up;
    do_reset;
    top = 3; en = 1;
    step(3);
    chk("R2 cnt at top", cnt, 3);
    chk("R2 no wrap yet", {31'd0, wrap}, 0);
    step(1);
    chk("R2 wrapped", cnt, 0);
    chk("R2 wrap pulse", {31'd0, wrap}, 1);
    step(1);
    chk("R2 pulse ends", {31'd0, wrap}, 0);
  endtask

  task automatic t_down;
    do_reset;
    dir = 1; top = 3; en = 1;
    step(1);
    chk("R3 to top", cnt, 3);
    chk("R3 wrap pulse", {31'd0, wrap}, 1);
    step(1);
    chk("R3 decrement", cnt, 2);
    chk("R3 pulse ends", {31'd0, wrap}, 0);
  endtask

  task automatic t_width;
    do_reset;
    wmode = 1; top = 32'h1FF; en = 1;
    step(255);
    chk("R4 8bit max", cnt, 32'hFF);
    step(1);
    chk("R4 8bit wrap", cnt, 0);
    chk("R4 8bit pulse", {31'd0, wrap}, 1);
    do_reset;
    wmode = 3; top = 32'h1_0005; en = 1;
    step(6);
    chk("R4 code3 as 16bit", {31'd0, wrap}, 1);
    do_reset;
    wmode = 2; dir = 1; top = 32'h1234_5678; en = 1;
    step(1);
    chk("R4 32bit top", cnt, 32'h1234_5678);
    do_reset;
    wmode = 0; dir = 1; top = 32'h1234_5678; en = 1;
    step(1);
    chk("R4 16bit top", cnt, 32'h5678);
  endtask

  task automatic retrig_setup(input logic [1:0] m);
    do_reset;
    smode = m; psel = 2; top = 32'hFFFF; en = 1;
    step(8);
    retrig = 1;
    step(1);
    retrig = 0;
  endtask

  task automatic t_sync0;
    retrig_setup(2'd0);
    chk("R5 reload now", cnt, 0);
    step(2);
    chk("R5 phase kept before", cnt, 0);
    step(1);
    chk("R5 phase kept tick", cnt, 1);
  endtask

  task automatic t_sync1;
    retrig_setup(2'd1);
    chk("R6 not yet", cnt, 2);
    step(2);
    chk("R6 still pending", cnt, 2);
    step(1);
    chk("R6 reload on tick", cnt, 0);
    step(4);
    chk("R6 counts after", cnt, 1);
  endtask

  task automatic t_sync2;
    retrig_setup(2'd2);
    chk("R7 reload now", cnt, 0);
    step(3);
    chk("R7 prescaler restarted", cnt, 0);
    step(1);
    chk("R7 full period", cnt, 1);
  endtask

  task automatic t_sync3;
    retrig_setup(2'd3);
    chk("R8 reload now", cnt, 0);
    step(3);
    chk("R8 phase kept", cnt, 1);
  endtask

  task automatic t_lock_on;
    do_reset;
    alock = 1; top = 3; en = 1;
    step(3);
    chk("R9 before wrap", {31'd0, lock}, 0);
    step(1);
    chk("R9 set on wrap", {31'd0, lock}, 1);
    lclr = 1; step(1); lclr = 0;
    chk("R9 cleared", {31'd0, lock}, 0);
    retrig = 1; step(1); retrig = 0;
    chk("R9 set on reload", {31'd0, lock}, 1);
    lclr = 1; retrig = 1; step(1); lclr = 0; retrig = 0;
    chk("R9 set beats clear", {31'd0, lock}, 1);
  endtask

  task automatic t_lock_off;
    do_reset;
    top = 3; en = 1;
    step(4);
    chk("R10 wrap seen", {31'd0, wrap}, 1);
    chk("R10 flag stays 0", {31'd0, lock}, 0);
    alock = 1; retrig = 1; step(1); retrig = 0; alock = 0;
    chk("R10 setup flag", {31'd0, lock}, 1);
    step(4);
    chk("R10 second wrap", {31'd0, wrap}, 1);
    chk("R10 flag stays 1", {31'd0, lock}, 1);
  endtask

  task automatic t_idle;
    do_reset;
    psel = 2; top = 32'hFFFF; en = 1;
    step(6);
    chk("R11 running", cnt, 1);
    en = 0; retrig = 1;
    step(3);
    retrig = 0;
    chk("R11 held", cnt, 1);
    chk("R11 no wrap", {31'd0, wrap}, 0);
    en = 1;
    step(3);
    chk("R11 prescaler zeroed", cnt, 1);
    step(1);
    chk("R11 resumes", cnt, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset;
    t_presc;
    t_up;
    t_down;
    t_width;
    t_sync0;
    t_sync1;
    t_sync2;
    t_sync3;
    t_lock_on;
    t_lock_off;
    t_idle;
    summary();
  end
endmodule